// File: doc/BRIEF.md
# Priority Clock Reference Selector

This block decides which recovered line clock feeds the system's phase-locked timing source. There are two classes of line interface, each with a parameterised number of slots: a primary-rate class and a basic-rate class. An internal free-running clock serves as the fallback. Each slot reports three things: whether a card is fitted (present), whether its recovered clock is currently valid (locked), and a one-cycle event when it gains carrier sync. The block drives out exactly one selected reference, given as a class and a slot, and pulses a strobe whenever that choice changes.

Selection is sticky. Within a class, the block picks the slot that gained sync earliest. It does not prefer the lowest slot number. Each slot holds an arrival stamp, taken from a per-class counter when its sync event fires. When the primary-rate slot in use drops, the block searches forward through the higher primary-rate slot numbers and wraps round to slot 0. If that full pass finds nothing, it takes the earliest-synced basic-rate slot, or the internal clock if there is none. While a lower class is in use, the block moves back up as soon as any primary-rate slot becomes usable. The block does not phase-lock, recover clocks or buffer slips. It only arbitrates.

Top module: `prc_ref_select`

## Requirements
- R1: During and after reset, until a line slot is usable (present and locked), the selection is the internal clock: `sel_class` = 2'd0 (internal), `sel_slot` = 0, `sw_pulse` = 0. Other class codes: 2'd1 = basic-rate, 2'd2 = primary-rate.
- R2: Class rank is primary-rate, then basic-rate, then internal. While the internal clock is in use and usable slots appear in both line classes, a primary-rate slot is chosen.
- R3: Within a class, a new choice goes to the usable slot whose sync event came first. When sync events arrive in the same cycle, the lower slot number wins.
- R4: While the selected slot stays present and locked, the selection does not change, even if another slot of the same class syncs or has an earlier stamp.
- R5: When the selected primary-rate slot stops being usable, the next choice is the first usable primary-rate slot found by stepping upward from the failed slot and wrapping from the top slot to slot 0. Removing the present flag counts as a failure.
- R6: When that forward search finds nothing, the earliest-synced usable basic-rate slot is chosen. If no basic-rate slot is usable, including the case where none is fitted, the internal clock is chosen.
- R7: While a basic-rate slot or the internal clock is in use, the block switches to the earliest usable primary-rate slot as soon as one exists.
- R8: When the selected basic-rate slot fails, the earliest remaining usable basic-rate slot is chosen. If there is none, the internal clock is chosen.
- R9: The selection is registered. Inputs sampled at one rising edge decide the outputs after that edge. `sw_pulse` is high for exactly the cycle after each change of class or slot, and low otherwise.
- R10: Only one reference is ever selected. A selected line slot was present and locked at the edge that chose or kept it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_present | input | N_PRI | Primary-rate slot fitted |
| pri_locked | input | N_PRI | Primary-rate recovered clock valid |
| pri_sync_evt | input | N_PRI | Primary-rate sync-acquired pulse |
| bri_present | input | N_BRI | Basic-rate slot fitted |
| bri_locked | input | N_BRI | Basic-rate recovered clock valid |
| bri_sync_evt | input | N_BRI | Basic-rate sync-acquired pulse |
| sel_class | output | 2 | Selected class: 0 internal, 1 basic-rate, 2 primary-rate |
| sel_slot | output | SLOT_W | Selected slot index (0 when internal) |
| sw_pulse | output | 1 | One-cycle strobe on every change of selection |

## Verification
The bench first syncs a high primary-rate slot and then a lower one. A design that picks by slot number would jump to the lower slot. It then fails the selected slot while a lower, earlier-stamped slot is still live. This separates a forward wrapping search from an earliest-stamp search, and a wrong design would land on the wrong slot. The bench also exercises:
- a same-cycle tie, where a wrong design would choose the higher slot;
- losing the present flag while still locked;
- primary-rate failure with basic-rate cards fitted but unsynced, where the answer must be the internal clock and not a dead basic-rate slot;
- basic-rate failover, which must follow stamp order.

The pulse is compared on every cycle. A design that pulses on a rewrite of the same value, or that misses a pulse on a class change, is caught.

// File: rtl/prc_pkg.sv
package prc_pkg;
  typedef enum logic [1:0] {
    SRC_INT = 2'd0,
    SRC_BRI = 2'd1,
    SRC_PRI = 2'd2
  } src_class_e;
endpackage

// File: rtl/prc_stamp_bank.sv
// Per-slot arrival stamps: a class-wide counter advances on every cycle that
// carries a sync event; each slot keeps the count present when it last synced.
module prc_stamp_bank #(
  parameter int N  = 4,
  parameter int SW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         evt,
  output logic [N-1:0][SW-1:0] eff_stamp
);
  localparam logic [SW-1:0] NEVER = {SW{1'b1}};
  localparam logic [SW-1:0] LAST  = NEVER - 1'b1;

  logic [SW-1:0]         cnt;
  logic [N-1:0][SW-1:0]  stamp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (|evt && cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        stamp[i] <= NEVER;
      end else if (evt[i]) begin
        stamp[i] <= cnt;
      end
    end
    // an event in this cycle already counts for this cycle's decision
    assign eff_stamp[i] = evt[i] ? cnt : stamp[i];
  end
endmodule

// File: rtl/prc_earliest.sv
// Finds the usable slot with the smallest stamp; lower index wins ties.
module prc_earliest #(
  parameter int N  = 4,
  parameter int SW = 8,
  parameter int IW = 2
) (
  input  logic [N-1:0]         use_ok,
  input  logic [N-1:0][SW-1:0] stamp,
  output logic                 found,
  output logic [IW-1:0]        idx
);
  logic [SW-1:0] best;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < N; i++) begin
      if (use_ok[i] && (!found || stamp[i] < best)) begin
        found = 1'b1;
        idx   = IW'(i);
        best  = stamp[i];
      end
    end
  end
endmodule

// File: rtl/prc_fwd_scan.sv
// Searches upward from the slot after 'start', wrapping to 0, one full pass.
module prc_fwd_scan #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  use_ok,
  input  logic [IW-1:0] start,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 1; k < N; k++) begin
      int j;
      j = int'(start) + k;
      if (j >= N) j = j - N;
      if (!found && use_ok[j]) begin
        found = 1'b1;
        idx   = IW'(j);
      end
    end
  end
endmodule

// File: rtl/prc_ref_select.sv
module prc_ref_select
  import prc_pkg::*;
#(
  parameter int N_PRI   = 4,
  parameter int N_BRI   = 4,
  parameter int STAMP_W = 8,
  localparam int MAXN   = (N_PRI > N_BRI) ? N_PRI : N_BRI,
  localparam int SLOT_W = (MAXN > 1) ? $clog2(MAXN) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PRI-1:0]  pri_present,
  input  logic [N_PRI-1:0]  pri_locked,
  input  logic [N_PRI-1:0]  pri_sync_evt,
  input  logic [N_BRI-1:0]  bri_present,
  input  logic [N_BRI-1:0]  bri_locked,
  input  logic [N_BRI-1:0]  bri_sync_evt,
  output logic [1:0]        sel_class,
  output logic [SLOT_W-1:0] sel_slot,
  output logic              sw_pulse
);
  localparam int PI_W = (N_PRI > 1) ? $clog2(N_PRI) : 1;
  localparam int BI_W = (N_BRI > 1) ? $clog2(N_BRI) : 1;

  logic [N_PRI-1:0] pri_use;
  logic [N_BRI-1:0] bri_use;
  assign pri_use = pri_present & pri_locked;
  assign bri_use = bri_present & bri_locked;

  logic [N_PRI-1:0][STAMP_W-1:0] pri_stamp;
  logic [N_BRI-1:0][STAMP_W-1:0] bri_stamp;

  prc_stamp_bank #(.N(N_PRI), .SW(STAMP_W)) u_pri_stamp (
    .clk(clk), .rst(rst), .evt(pri_sync_evt), .eff_stamp(pri_stamp));
  prc_stamp_bank #(.N(N_BRI), .SW(STAMP_W)) u_bri_stamp (
    .clk(clk), .rst(rst), .evt(bri_sync_evt), .eff_stamp(bri_stamp));

  logic            pri_e_found, bri_e_found, scan_found;
  logic [PI_W-1:0] pri_e_idx, scan_idx;
  logic [BI_W-1:0] bri_e_idx;

  prc_earliest #(.N(N_PRI), .SW(STAMP_W), .IW(PI_W)) u_pri_first (
    .use_ok(pri_use), .stamp(pri_stamp), .found(pri_e_found), .idx(pri_e_idx));
  prc_earliest #(.N(N_BRI), .SW(STAMP_W), .IW(BI_W)) u_bri_first (
    .use_ok(bri_use), .stamp(bri_stamp), .found(bri_e_found), .idx(bri_e_idx));

  src_class_e        cur_cls, nxt_cls;
  logic [SLOT_W-1:0] nxt_slot;
  logic [PI_W-1:0]   cur_pi;
  logic [BI_W-1:0]   cur_bi;

  assign cur_pi = sel_slot[PI_W-1:0];
  assign cur_bi = sel_slot[BI_W-1:0];
  assign cur_cls = src_class_e'(sel_class);

  prc_fwd_scan #(.N(N_PRI), .IW(PI_W)) u_pri_scan (
    .use_ok(pri_use), .start(cur_pi), .found(scan_found), .idx(scan_idx));

  always_comb begin
    nxt_cls  = cur_cls;
    nxt_slot = sel_slot;
    case (cur_cls)
      SRC_PRI: begin
        if (!pri_use[cur_pi]) begin
          if (scan_found) begin
            nxt_cls  = SRC_PRI;
            nxt_slot = SLOT_W'(scan_idx);
          end else if (bri_e_found) begin
            nxt_cls  = SRC_BRI;
            nxt_slot = SLOT_W'(bri_e_idx);
          end else begin
            nxt_cls  = SRC_INT;
            nxt_slot = '0;
          end
        end
      end
      SRC_BRI: begin
        if (pri_e_found) begin
          nxt_cls  = SRC_PRI;
          nxt_slot = SLOT_W'(pri_e_idx);
        end else if (!bri_use[cur_bi]) begin
          if (bri_e_found) begin
            nxt_cls  = SRC_BRI;
            nxt_slot = SLOT_W'(bri_e_idx);
          end else begin
            nxt_cls  = SRC_INT;
            nxt_slot = '0;
          end
        end
      end
      default: begin
        if (pri_e_found) begin
          nxt_cls  = SRC_PRI;
          nxt_slot = SLOT_W'(pri_e_idx);
        end else if (bri_e_found) begin
          nxt_cls  = SRC_BRI;
          nxt_slot = SLOT_W'(bri_e_idx);
        end else begin
          nxt_cls  = SRC_INT;
          nxt_slot = '0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_class <= SRC_INT;
      sel_slot  <= '0;
      sw_pulse  <= 1'b0;
    end else begin
      sel_class <= nxt_cls;
      sel_slot  <= nxt_slot;
      sw_pulse  <= (nxt_cls != cur_cls) || (nxt_slot != sel_slot);
    end
  end
endmodule

// File: rtl/prc_ref_select_chk.sv
module prc_ref_select_chk #(
  parameter int N_PRI  = 4,
  parameter int N_BRI  = 4,
  parameter int SLOT_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [N_PRI-1:0]  pri_present,
  input logic [N_PRI-1:0]  pri_locked,
  input logic [N_BRI-1:0]  bri_present,
  input logic [N_BRI-1:0]  bri_locked,
  input logic [1:0]        sel_class,
  input logic [SLOT_W-1:0] sel_slot,
  input logic              sw_pulse
);
  logic [N_PRI-1:0] q_pri;
  logic [N_BRI-1:0] q_bri;

  always_ff @(posedge clk) begin
    if (rst) begin
      q_pri <= '0;
      q_bri <= '0;
    end else begin
      q_pri <= pri_present & pri_locked;
      q_bri <= bri_present & bri_locked;
    end
  end

  assert_valid_class_R10: assert property (@(posedge clk) disable iff (rst)
    sel_class != 2'd3);

  assert_pri_was_usable_R10: assert property (@(posedge clk) disable iff (rst)
    (sel_class == 2'd2) |-> q_pri[sel_slot]);

  assert_bri_was_usable_R10: assert property (@(posedge clk) disable iff (rst)
    (sel_class == 2'd1) |-> q_bri[sel_slot]);

  assert_internal_iff_idle_R6: assert property (@(posedge clk) disable iff (rst)
    (sel_class == 2'd0) == (q_pri == '0 && q_bri == '0));

  assert_bri_only_without_pri_R7: assert property (@(posedge clk) disable iff (rst)
    (sel_class == 2'd1) |-> (q_pri == '0));

  assert_sticky_pri_R4: assert property (@(posedge clk) disable iff (rst)
    (sel_class == 2'd2 && pri_present[sel_slot] && pri_locked[sel_slot])
      |=> (sel_class == 2'd2 && $stable(sel_slot)));

  assert_pulse_on_change_R9: assert property (@(posedge clk) disable iff (rst)
    sw_pulse == ((sel_class != $past(sel_class)) || (sel_slot != $past(sel_slot))));
endmodule

bind prc_ref_select prc_ref_select_chk #(
  .N_PRI(N_PRI), .N_BRI(N_BRI), .SLOT_W(SLOT_W)
) u_chk (
  .clk(clk), .rst(rst),
  .pri_present(pri_present), .pri_locked(pri_locked),
  .bri_present(bri_present), .bri_locked(bri_locked),
  .sel_class(sel_class), .sel_slot(sel_slot), .sw_pulse(sw_pulse)
);

// File: tb/tb_prc_ref_select.sv
module tb_prc_ref_select;
  localparam int NP = 4;
  localparam int NB = 3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pp = '0, pl = '0, pe = '0;
  logic [NB-1:0] bp = '0, bl = '0, be = '0;
  logic [1:0]    sel_class;
  logic [1:0]    sel_slot;
  logic          sw_pulse;

  always #10 clk = ~clk;

  prc_ref_select #(.N_PRI(NP), .N_BRI(NB), .STAMP_W(8)) dut (
    .clk(clk), .rst(rst),
    .pri_present(pp), .pri_locked(pl), .pri_sync_evt(pe),
    .bri_present(bp), .bri_locked(bl), .bri_sync_evt(be),
    .sel_class(sel_class), .sel_slot(sel_slot), .sw_pulse(sw_pulse));

  typedef struct {
    logic [1:0] cls;
    logic [1:0] slot;
    logic       pulse;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  task automatic compare(input string tag, input logic [1:0] c, input logic [1:0] s,
                         input logic p);
    checks++;
    if (sel_class !== c || sel_slot !== s || sw_pulse !== p) begin
      errors++;
      $display("FAIL %s: got class=%0d slot=%0d pulse=%0d exp class=%0d slot=%0d pulse=%0d",
               tag, sel_class, sel_slot, sw_pulse, c, s, p);
    end
  endtask

  // driver: apply one cycle of inputs and queue the expected outputs
  task automatic step(input logic [NP-1:0] ipp, ipl, ipe,
                      input logic [NB-1:0] ibp, ibl, ibe,
                      input logic [1:0] c, input logic [1:0] s, input logic p,
                      input string tag);
    exp_t e;
    @(negedge clk);
    pp = ipp; pl = ipl; pe = ipe;
    bp = ibp; bl = ibl; be = ibe;
    e.cls = c; e.slot = s; e.pulse = p; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: results of the edge just passed
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        compare(e.tag, e.cls, e.slot, e.pulse);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    compare("R1 reset state", 2'd0, 2'd0, 1'b0);
    @(negedge clk);
    rst = 1'b0;
    // primaries fitted, no basic-rate cards, nothing locked
    step(4'b1111, 4'b0000, 4'b0000, 3'b000, 3'b000, 3'b000, 2'd0, 2'd0, 1'b0, "R1 idle internal");
    step(4'b1111, 4'b0100, 4'b0100, 3'b000, 3'b000, 3'b000, 2'd2, 2'd2, 1'b1, "R2 first primary sync");
    step(4'b1111, 4'b0101, 4'b0001, 3'b000, 3'b000, 3'b000, 2'd2, 2'd2, 1'b0, "R4 lower slot syncs later");
    step(4'b1111, 4'b1101, 4'b1000, 3'b000, 3'b000, 3'b000, 2'd2, 2'd2, 1'b0, "R4 another syncs");
    step(4'b1111, 4'b1001, 4'b0000, 3'b000, 3'b000, 3'b000, 2'd2, 2'd3, 1'b1, "R5 forward scan");
    step(4'b1111, 4'b1001, 4'b0000, 3'b000, 3'b000, 3'b000, 2'd2, 2'd3, 1'b0, "R9 no pulse hold");
    step(4'b1111, 4'b0001, 4'b0000, 3'b000, 3'b000, 3'b000, 2'd2, 2'd0, 1'b1, "R5 wrap to slot 0");
    step(4'b1111, 4'b0000, 4'b0000, 3'b000, 3'b000, 3'b000, 2'd0, 2'd0, 1'b1, "R6 no basic fitted");
    step(4'b1111, 4'b0000, 4'b0000, 3'b111, 3'b000, 3'b000, 2'd0, 2'd0, 1'b0, "R6 basic fitted unsynced");
    step(4'b1111, 4'b0000, 4'b0000, 3'b111, 3'b110, 3'b110, 2'd1, 2'd1, 1'b1, "R3 basic tie lower slot");
    step(4'b1111, 4'b0000, 4'b0000, 3'b111, 3'b111, 3'b001, 2'd1, 2'd1, 1'b0, "R4 basic sticky");
    step(4'b1111, 4'b0010, 4'b0010, 3'b111, 3'b111, 3'b000, 2'd2, 2'd1, 1'b1, "R7 back to primary");
    step(4'b1111, 4'b0000, 4'b0000, 3'b111, 3'b111, 3'b000, 2'd1, 2'd1, 1'b1, "R6 primary fail to basic");
    step(4'b1111, 4'b0000, 4'b0000, 3'b111, 3'b101, 3'b000, 2'd1, 2'd2, 1'b1, "R8 basic earliest stamp");
    step(4'b1111, 4'b0000, 4'b0000, 3'b111, 3'b000, 3'b000, 2'd0, 2'd0, 1'b1, "R8 basic none left");
    step(4'b1111, 4'b0001, 4'b0001, 3'b111, 3'b000, 3'b000, 2'd2, 2'd0, 1'b1, "R2 primary from internal");
    step(4'b1111, 4'b0000, 4'b0000, 3'b111, 3'b000, 3'b000, 2'd0, 2'd0, 1'b1, "R6 basic fitted none synced");
    step(4'b1111, 4'b1010, 4'b1010, 3'b111, 3'b001, 3'b001, 2'd2, 2'd1, 1'b1, "R3 primary tie over basic");
    step(4'b1101, 4'b1010, 4'b0000, 3'b111, 3'b001, 3'b000, 2'd2, 2'd3, 1'b1, "R5 present dropped");
    step(4'b1101, 4'b1010, 4'b0000, 3'b111, 3'b001, 3'b000, 2'd2, 2'd3, 1'b0, "R10 steady single ref");
    step(4'b0000, 4'b0000, 4'b0000, 3'b111, 3'b001, 3'b000, 2'd1, 2'd0, 1'b1, "R6 all primary gone");
    step(4'b0000, 4'b0000, 4'b0000, 3'b111, 3'b001, 3'b000, 2'd1, 2'd0, 1'b0, "R9 no pulse basic hold");
    while (q.size() > 0) @(posedge clk);
    #5;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule